// File: doc/BRIEF.md
# Loop-Counter Conditional Branch Resolver

This block resolves one branch request per clock cycle. It decides whether the branch is taken and produces the next program counter. It holds two architectural registers: a link register for return addresses and a loop counter. The decision combines two tests. The first is an optional test of one bit of an externally supplied 32-bit condition word. The second is an optional decrement-then-test of the loop counter. Together these give nine distinct branch conditions, including an unconditional branch.

The target comes from one of three sources. A direct request uses a word displacement, either added to the current PC or taken as an absolute address. An indirect request takes its target from the link register, which is the return path, or from the loop counter. A request can also store the address of the following instruction in the link register, which makes it a call. Decode supplies the request fields. Dedicated load ports let software-visible move operations set either register.

The taken flag, the next PC and the illegal flag are combinational from the request and the current register values. Register updates land on the next rising clock edge.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `count_q` and `link_q` read 0, and `taken` and `illegal` are 0 while `req_valid` is low.
- R2: The option bits are `opts[0]` skip-condition, `opts[1]` wanted sense, `opts[2]` skip-decrement and `opts[3]` want-zero. When `opts[0]` is 0, the condition test passes only if bit `cond_sel` of `cond_word` equals `opts[1]`. When `opts[0]` is 1, the condition word has no effect.
- R3: When `opts[2]` is 0, a valid legal request decrements `count_q` by one (modulo 2^32) on the next edge, whether or not the branch is taken. The counter test uses the decremented value: with `opts[3]` = 1 it passes when that value is zero, and with `opts[3]` = 0 it passes when the value is nonzero. When `opts[2]` is 1, the counter is neither tested nor changed.
- R4: `taken` is 1 only when `req_valid` is 1, the request is legal, and both tests pass. This covers all nine option combinations. When `req_valid` is 0, `taken` is 0 and no register changes.
- R5: For a direct request (`br_kind` = 0) with `abs_mode` = 0, the target is `cur_pc` plus the sign-extended `disp` shifted left by two.
- R6: For a direct request with `abs_mode` = 1, the target is the sign-extended `disp` shifted left by two, independent of `cur_pc`.
- R7: When `taken` is 0, `next_pc` is `cur_pc` + 4. When `taken` is 1, `next_pc` is the target.
- R8: When `link_en` is 1 on a valid legal request, `link_q` becomes `cur_pc` + 4 on the next edge, whether or not the branch is taken. When `link_en` is 0, `link_q` is unchanged.
- R9: For `br_kind` = 1, the target is `link_q` with its two low bits cleared. The value used is the one held before any link write made by the same request. `abs_mode` has no effect.
- R10: For `br_kind` = 2, the target is `count_q` with its two low bits cleared, and `abs_mode` has no effect.
- R11: A request is illegal when `br_kind` = 2 with `opts[2]` = 0, or when `br_kind` = 3. For an illegal request, `illegal` is 1, `taken` is 0, `next_pc` is `cur_pc` + 4, and neither register changes.
- R12: `cnt_ld_en` loads `cnt_ld_val` into the counter and `lnk_ld_en` loads `lnk_ld_val` into the link register on the next edge. Each load overrides a branch update to the same register in that cycle.
- R13: `opts[4]` has no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A branch request is present this cycle |
| opts | input | 5 | Branch option bits |
| cond_sel | input | 5 | Index of the tested condition bit |
| cond_word | input | 32 | Condition word |
| abs_mode | input | 1 | Direct target is absolute |
| link_en | input | 1 | Write return address to link register |
| br_kind | input | 2 | 0 direct, 1 via link, 2 via counter, 3 reserved |
| disp | input | 24 | Word displacement, signed |
| cur_pc | input | 32 | Address of the branch |
| cnt_ld_en | input | 1 | Load counter |
| cnt_ld_val | input | 32 | Counter load value |
| lnk_ld_en | input | 1 | Load link register |
| lnk_ld_val | input | 32 | Link load value |
| taken | output | 1 | Branch taken |
| next_pc | output | 32 | Next fetch address |
| illegal | output | 1 | Illegal request flag |
| count_q | output | 32 | Loop counter |
| link_q | output | 32 | Link register |

## Verification
The hardest cases to reach from the ports combine register state with the request. Examples are a counter wrapping from zero to all ones under a decrement, and a return through the link register that also writes the link register in the same cycle. Reaching either needs a chosen value already held when the request arrives. Each stimulus vector therefore first loads both registers through the load ports with values picked for that case. It then issues the request and checks the combinational decision, followed by the register values after the edge. Unaligned preloads show that the low target bits are cleared. A directed test presents a load and a decrementing branch together to check load priority.

// File: rtl/br_res_pkg.sv
package br_res_pkg;
  typedef enum logic [1:0] {
    KIND_DIRECT    = 2'd0,
    KIND_VIA_LINK  = 2'd1,
    KIND_VIA_COUNT = 2'd2,
    KIND_RESERVED  = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic spare;
    logic want_zero;
    logic skip_dec;
    logic want_true;
    logic skip_cond;
  } br_opts_t;
endpackage

// File: rtl/br_res_rst_sync.sv
module br_res_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/br_res_test.sv
module br_res_test
  import br_res_pkg::*;
#(
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  br_opts_t                 opts,
  input  logic [SEL_W-1:0]         cond_sel,
  input  logic [(1<<SEL_W)-1:0]    cond_word,
  input  logic [ADDR_W-1:0]        cnt_q,
  output logic [ADDR_W-1:0]        cnt_dec,
  output logic                     dec_req,
  output logic                     test_pass
);
  logic cond_bit;
  logic cond_ok;
  logic cnt_zero;
  logic cnt_ok;

  always_comb begin
    cond_bit  = cond_word[cond_sel];
    cond_ok   = opts.skip_cond | (cond_bit == opts.want_true);
    cnt_dec   = cnt_q - ADDR_W'(1);
    cnt_zero  = (cnt_dec == '0);
    cnt_ok    = opts.skip_dec | (cnt_zero == opts.want_zero);
    dec_req   = ~opts.skip_dec;
    test_pass = cond_ok & cnt_ok;
  end

  // R3: counter at one, decrement-and-branch-on-zero with no condition test passes
  p_zero_after_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!opts.skip_dec && opts.skip_cond && opts.want_zero && cnt_q == ADDR_W'(1)) |-> test_pass);

  // R2: a mismatching condition bit always blocks when the condition is tested
  p_cond_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!opts.skip_cond && cond_word[cond_sel] != opts.want_true) |-> !test_pass);
endmodule

// File: rtl/br_res_target.sv
module br_res_target
  import br_res_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 24
) (
  input  br_kind_e            kind,
  input  logic                abs_mode,
  input  logic [DISP_W-1:0]   disp,
  input  logic [ADDR_W-1:0]   cur_pc,
  input  logic [ADDR_W-1:0]   lnk_q,
  input  logic [ADDR_W-1:0]   cnt_q,
  output logic [ADDR_W-1:0]   target,
  output logic [ADDR_W-1:0]   seq_pc
);
  localparam int unsigned EXT_W = ADDR_W - DISP_W - 2;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] raw_tgt;

  always_comb begin
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp, 2'b00};
    seq_pc   = cur_pc + ADDR_W'(4);
    unique case (kind)
      KIND_VIA_LINK:  raw_tgt = lnk_q;
      KIND_VIA_COUNT: raw_tgt = cnt_q;
      default:        raw_tgt = abs_mode ? disp_ext : (cur_pc + disp_ext);
    endcase
    target = {raw_tgt[ADDR_W-1:2], 2'b00};
  end
endmodule

// File: rtl/br_res_regs.sv
module br_res_regs #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_ld_en,
  input  logic [ADDR_W-1:0] cnt_ld_val,
  input  logic              lnk_ld_en,
  input  logic [ADDR_W-1:0] lnk_ld_val,
  input  logic              dec_fire,
  input  logic [ADDR_W-1:0] dec_val,
  input  logic              lnk_fire,
  input  logic [ADDR_W-1:0] lnk_val,
  output logic [ADDR_W-1:0] cnt_q,
  output logic [ADDR_W-1:0] lnk_q
);
  logic              cnt_en;
  logic              lnk_en;
  logic [ADDR_W-1:0] cnt_d;
  logic [ADDR_W-1:0] lnk_d;
  logic              arm_q;

  always_comb begin
    cnt_en = cnt_ld_en | dec_fire;
    cnt_d  = cnt_ld_en ? cnt_ld_val : dec_val;
    lnk_en = lnk_ld_en | lnk_fire;
    lnk_d  = lnk_ld_en ? lnk_ld_val : lnk_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lnk_q <= '0;
      arm_q <= 1'b0;
    end else begin
      arm_q <= 1'b1;
      if (cnt_en) cnt_q <= cnt_d;
      if (lnk_en) lnk_q <= lnk_d;
    end
  end

  // R3: a decrement lowers the counter by exactly one
  p_dec_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && $past(dec_fire) && !$past(cnt_ld_en)) |-> (cnt_q == $past(cnt_q) - ADDR_W'(1)));

  // R12: a load wins over a branch update
  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && $past(cnt_ld_en)) |-> (cnt_q == $past(cnt_ld_val)));

  // R8: a link write stores the supplied return address
  p_link_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && $past(lnk_fire) && !$past(lnk_ld_en)) |-> (lnk_q == $past(lnk_val)));

  // R4: with nothing requested both registers hold
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && !$past(cnt_en) && !$past(lnk_en)) |-> ($stable(cnt_q) && $stable(lnk_q)));
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_res_pkg::*;
#(
  parameter int unsigned SEL_W  = 5,
  parameter int unsigned OPT_W  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [OPT_W-1:0]      opts,
  input  logic [SEL_W-1:0]      cond_sel,
  input  logic [(1<<SEL_W)-1:0] cond_word,
  input  logic                  abs_mode,
  input  logic                  link_en,
  input  logic [1:0]            br_kind,
  input  logic [DISP_W-1:0]     disp,
  input  logic [ADDR_W-1:0]     cur_pc,
  input  logic                  cnt_ld_en,
  input  logic [ADDR_W-1:0]     cnt_ld_val,
  input  logic                  lnk_ld_en,
  input  logic [ADDR_W-1:0]     lnk_ld_val,
  output logic                  taken,
  output logic [ADDR_W-1:0]     next_pc,
  output logic                  illegal,
  output logic [ADDR_W-1:0]     count_q,
  output logic [ADDR_W-1:0]     link_q
);
  logic              rst_sync_n;
  br_opts_t          opt_s;
  br_kind_e          kind;
  logic [ADDR_W-1:0] cnt_dec;
  logic              dec_req;
  logic              test_pass;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] seq_pc;
  logic              bad_req;
  logic              legal_fire;
  logic              dec_fire;
  logic              lnk_fire;

  br_res_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    opt_s = br_opts_t'(opts);
    kind  = br_kind_e'(br_kind);
  end

  br_res_test #(.SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_test (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .opts      (opt_s),
    .cond_sel  (cond_sel),
    .cond_word (cond_word),
    .cnt_q     (count_q),
    .cnt_dec   (cnt_dec),
    .dec_req   (dec_req),
    .test_pass (test_pass)
  );

  br_res_target #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .kind     (kind),
    .abs_mode (abs_mode),
    .disp     (disp),
    .cur_pc   (cur_pc),
    .lnk_q    (link_q),
    .cnt_q    (count_q),
    .target   (target),
    .seq_pc   (seq_pc)
  );

  always_comb begin
    bad_req    = req_valid & (((kind == KIND_VIA_COUNT) & dec_req) | (kind == KIND_RESERVED));
    legal_fire = req_valid & ~bad_req;
    taken      = legal_fire & test_pass;
    next_pc    = taken ? target : seq_pc;
    illegal    = bad_req;
    dec_fire   = legal_fire & dec_req;
    lnk_fire   = legal_fire & link_en;
  end

  br_res_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cnt_ld_en  (cnt_ld_en),
    .cnt_ld_val (cnt_ld_val),
    .lnk_ld_en  (lnk_ld_en),
    .lnk_ld_val (lnk_ld_val),
    .dec_fire   (dec_fire),
    .dec_val    (cnt_dec),
    .lnk_fire   (lnk_fire),
    .lnk_val    (seq_pc),
    .cnt_q      (count_q),
    .lnk_q      (link_q)
  );

  // R7: a request that falls through goes to the next word
  p_fallthru_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !taken) |-> (next_pc == cur_pc + ADDR_W'(4)));

  // R11: an illegal request leaves both registers untouched
  p_illegal_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (illegal && !cnt_ld_en && !lnk_ld_en) |=> ($stable(count_q) && $stable(link_q)));

  // R9: a return through the link register uses the value held before the write
  p_link_target_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (taken && kind == KIND_VIA_LINK) |-> (next_pc == {link_q[ADDR_W-1:2], 2'b00}));
endmodule

// File: tb/tb_branch_resolver.sv
module tb_branch_resolver;
  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  opts;
    logic        cbit;
    logic [4:0]  sel;
    logic        aa;
    logic        lk;
    logic [23:0] disp;
    logic [31:0] pc;
    logic [31:0] ctr0;
    logic [31:0] lnk0;
    logic        e_tk;
    logic [31:0] e_npc;
    logic [31:0] e_ctr;
    logic [31:0] e_lnk;
    logic        e_ill;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    // R3 R4: decrement, nonzero, condition false
    '{2'd0, 5'b00000, 1'b0, 5'd3,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd5, 32'h200, 1'b1, 32'h1010, 32'd4, 32'h200, 1'b0},
    '{2'd0, 5'b00000, 1'b0, 5'd3,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd1, 32'h200, 1'b0, 32'h1004, 32'd0, 32'h200, 1'b0},
    // decrement, zero, condition false
    '{2'd0, 5'b01000, 1'b0, 5'd7,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd1, 32'h200, 1'b1, 32'h1010, 32'd0, 32'h200, 1'b0},
    '{2'd0, 5'b01000, 1'b1, 5'd7,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd1, 32'h200, 1'b0, 32'h1004, 32'd0, 32'h200, 1'b0},
    // decrement nonzero / zero, condition true
    '{2'd0, 5'b00010, 1'b1, 5'd31, 1'b0, 1'b0, 24'd4, 32'h1000, 32'd3, 32'h200, 1'b1, 32'h1010, 32'd2, 32'h200, 1'b0},
    '{2'd0, 5'b01010, 1'b1, 5'd0,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd1, 32'h200, 1'b1, 32'h1010, 32'd0, 32'h200, 1'b0},
    // R2: condition only, counter untouched
    '{2'd0, 5'b00100, 1'b0, 5'd12, 1'b0, 1'b0, 24'd4, 32'h1000, 32'd7, 32'h200, 1'b1, 32'h1010, 32'd7, 32'h200, 1'b0},
    '{2'd0, 5'b00110, 1'b0, 5'd12, 1'b0, 1'b0, 24'd4, 32'h1000, 32'd7, 32'h200, 1'b0, 32'h1004, 32'd7, 32'h200, 1'b0},
    // counter only: wrap from zero, and zero test miss
    '{2'd0, 5'b00001, 1'b0, 5'd2,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd0, 32'h200, 1'b1, 32'h1010, 32'hFFFF_FFFF, 32'h200, 1'b0},
    '{2'd0, 5'b01001, 1'b1, 5'd2,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd2, 32'h200, 1'b0, 32'h1004, 32'd1, 32'h200, 1'b0},
    // R6: always, absolute negative displacement
    '{2'd0, 5'b00101, 1'b0, 5'd2,  1'b1, 1'b0, 24'hFFFFFC, 32'h1000, 32'd9, 32'h200, 1'b1, 32'hFFFF_FFF0, 32'd9, 32'h200, 1'b0},
    // R5: relative negative displacement
    '{2'd0, 5'b00101, 1'b0, 5'd2,  1'b0, 1'b0, 24'hFFFFFC, 32'h1000, 32'd9, 32'h200, 1'b1, 32'h0000_0FF0, 32'd9, 32'h200, 1'b0},
    // R8: call taken, then call not taken still links
    '{2'd0, 5'b00101, 1'b0, 5'd2,  1'b0, 1'b1, 24'd4, 32'h1000, 32'd9, 32'h200, 1'b1, 32'h1010, 32'd9, 32'h1004, 1'b0},
    '{2'd0, 5'b00110, 1'b0, 5'd9,  1'b0, 1'b1, 24'd4, 32'h1000, 32'd9, 32'h200, 1'b0, 32'h1004, 32'd9, 32'h1004, 1'b0},
    // R9: return via link with link write, unaligned link, AA ignored
    '{2'd1, 5'b00101, 1'b0, 5'd0,  1'b1, 1'b1, 24'd4, 32'h1000, 32'd9, 32'h2003, 1'b1, 32'h2000, 32'd9, 32'h1004, 1'b0},
    // R10: via counter, unaligned, AA ignored
    '{2'd2, 5'b00101, 1'b0, 5'd0,  1'b1, 1'b0, 24'd4, 32'h1000, 32'h3007, 32'h200, 1'b1, 32'h3004, 32'h3007, 32'h200, 1'b0},
    // R11: via counter with decrement, reserved kind
    '{2'd2, 5'b00001, 1'b0, 5'd0,  1'b0, 1'b1, 24'd4, 32'h1000, 32'h3007, 32'h200, 1'b0, 32'h1004, 32'h3007, 32'h200, 1'b1},
    '{2'd3, 5'b00101, 1'b0, 5'd0,  1'b0, 1'b1, 24'd4, 32'h1000, 32'd5, 32'h200, 1'b0, 32'h1004, 32'd5, 32'h200, 1'b1},
    // R13: spare option bit set
    '{2'd0, 5'b10000, 1'b0, 5'd3,  1'b0, 1'b0, 24'd4, 32'h1000, 32'd5, 32'h200, 1'b1, 32'h1010, 32'd4, 32'h200, 1'b0},
    '{2'd0, 5'b10110, 1'b1, 5'd20, 1'b0, 1'b0, 24'd4, 32'h1000, 32'd5, 32'h200, 1'b1, 32'h1010, 32'd5, 32'h200, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [4:0]  opts;
  logic [4:0]  cond_sel;
  logic [31:0] cond_word;
  logic        abs_mode;
  logic        link_en;
  logic [1:0]  br_kind;
  logic [23:0] disp;
  logic [31:0] cur_pc;
  logic        cnt_ld_en;
  logic [31:0] cnt_ld_val;
  logic        lnk_ld_en;
  logic [31:0] lnk_ld_val;
  logic        taken;
  logic [31:0] next_pc;
  logic        illegal;
  logic [31:0] count_q;
  logic [31:0] link_q;

  int checks;
  int errors;

  branch_resolver dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .opts(opts),
    .cond_sel(cond_sel), .cond_word(cond_word), .abs_mode(abs_mode),
    .link_en(link_en), .br_kind(br_kind), .disp(disp), .cur_pc(cur_pc),
    .cnt_ld_en(cnt_ld_en), .cnt_ld_val(cnt_ld_val), .lnk_ld_en(lnk_ld_en),
    .lnk_ld_val(lnk_ld_val), .taken(taken), .next_pc(next_pc),
    .illegal(illegal), .count_q(count_q), .link_q(link_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; opts = '0; cond_sel = '0; cond_word = '0;
    abs_mode = 1'b0; link_en = 1'b0; br_kind = 2'd0; disp = '0;
    cur_pc = 32'h1000; cnt_ld_en = 1'b0; cnt_ld_val = '0;
    lnk_ld_en = 1'b0; lnk_ld_val = '0;
  endtask

  task automatic preload(input logic [31:0] c, input logic [31:0] l);
    @(negedge clk);
    idle();
    cnt_ld_en = 1'b1; cnt_ld_val = c;
    lnk_ld_en = 1'b1; lnk_ld_val = l;
    @(negedge clk);
    cnt_ld_en = 1'b0; lnk_ld_en = 1'b0;
  endtask

  initial begin
    checks = 0; errors = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 count", count_q, 32'd0);
    check("R1 link", link_q, 32'd0);
    check("R1 taken", {31'd0, taken}, 32'd0);
    check("R1 illegal", {31'd0, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      preload(VECS[i].ctr0, VECS[i].lnk0);
      req_valid = 1'b1;
      opts      = VECS[i].opts;
      cond_sel  = VECS[i].sel;
      cond_word = VECS[i].cbit ? (32'h1 << VECS[i].sel) : ~(32'h1 << VECS[i].sel);
      abs_mode  = VECS[i].aa;
      link_en   = VECS[i].lk;
      br_kind   = VECS[i].kind;
      disp      = VECS[i].disp;
      cur_pc    = VECS[i].pc;
      #1;
      check($sformatf("R4 R2 R3 taken v%0d", i), {31'd0, taken}, {31'd0, VECS[i].e_tk});
      check($sformatf("R5 R6 R7 R9 R10 next_pc v%0d", i), next_pc, VECS[i].e_npc);
      check($sformatf("R11 illegal v%0d", i), {31'd0, illegal}, {31'd0, VECS[i].e_ill});
      @(negedge clk);
      idle();
      check($sformatf("R3 count v%0d", i), count_q, VECS[i].e_ctr);
      check($sformatf("R8 link v%0d", i), link_q, VECS[i].e_lnk);
    end

    // R4: request not valid has no effect
    preload(32'd1, 32'h40);
    opts = 5'b01001; link_en = 1'b1; req_valid = 1'b0;
    #1 check("R4 taken when invalid", {31'd0, taken}, 32'd0);
    @(negedge clk);
    check("R4 count when invalid", count_q, 32'd1);
    check("R4 link when invalid", link_q, 32'h40);

    // R12: load and decrementing call in the same cycle
    idle();
    req_valid = 1'b1; opts = 5'b00001; link_en = 1'b1;
    cnt_ld_en = 1'b1; cnt_ld_val = 32'h55;
    lnk_ld_en = 1'b1; lnk_ld_val = 32'h77;
    @(negedge clk);
    idle();
    check("R12 count load wins", count_q, 32'h55);
    check("R12 link load wins", link_q, 32'h77);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule